// File: doc/BRIEF.md
# Transmit Lane Skew Calibration Controller

This controller removes the timing skew between transmit lanes and can then insert a programmed skew on purpose. An early/late phase detector compares two lanes and delivers one sign sample per valid strobe. The controller groups the samples into majority-vote decisions and moves a signed offset word by one code per decision. That word sets a charge-pump offset current in the transmit PLL, and so the phase of one lane.

The offset word does not drive the current directly. It feeds a first-order delta-sigma stage whose 1-bit carry stream would switch a unit offset current. The average current therefore resolves phase much more finely than a static current DAC of the same step. Calibration starts on a start pulse. The state machine first searches for the zero-skew point. It then adds the requested pre-compensation skew once, clamped below one unit interval. After that it keeps tracking around the new point so the skew holds while conditions drift, and it raises a lock flag once tracking has settled.

States: IDLE (after reset, detector ignored), ZERO_SEARCH (auto-zero), APPLY_TARGET (one cycle that captures the clamped target), TRACK (tracking with the target added), LOCKED (tracking, lock flag high). Transitions: IDLE to ZERO_SEARCH on start. ZERO_SEARCH to APPLY_TARGET after LOCK_N consecutive sign alternations. APPLY_TARGET to TRACK unconditionally. TRACK to LOCKED after LOCK_N consecutive alternations. Any state to ZERO_SEARCH on start.

Top module: `skew_trim_ctrl`

## Requirements
- R1: After reset the offset word is 0, the lock flag is 0, the modulator output is 0, and the controller is in IDLE.
- R2: In IDLE, detector samples are ignored: the offset word does not change until a start pulse.
- R3: In ZERO_SEARCH, TRACK and LOCKED, every VOTE_N accepted samples (pd_valid high) form one decision. If more than VOTE_N/2 of them are late (pd_late=1), the offset rises by 1. Otherwise it falls by 1, so an exact tie counts as early.
- R4: ZERO_SEARCH ends once LOCK_N consecutive decisions have each had the opposite sign to the one before (LOCK_N+1 decisions in all). The controller then spends one cycle in APPLY_TARGET and moves to TRACK, and the offset word jumps by the clamped target.
- R5: The target captured in APPLY_TARGET is tgt_skew clamped to the range -(UI_CODE-1) to +(UI_CODE-1).
- R6: In TRACK, decisions keep moving the tracked base while the target stays added. After LOCK_N consecutive alternations the controller enters LOCKED and raises locked.
- R7: In LOCKED, decisions keep moving the offset word and locked stays high.
- R8: The tracked base and the offset word both saturate at ±(2^(OFS_W-1)-1) and never wrap.
- R9: While the offset word is constant, any 2^OFS_W consecutive modulator output bits contain exactly offset_word + 2^(OFS_W-1) ones.
- R10: A start pulse in any state returns the controller to ZERO_SEARCH. It clears the target, locked, the partial vote and the alternation history. A final vote sample that arrives in the same cycle as start produces no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start | input | 1 | One-cycle pulse that starts or restarts calibration |
| tgt_skew | input | OFS_W | Requested skew, signed, in offset codes; UI_CODE codes equal one unit interval |
| pd_valid | input | 1 | Phase detector sample strobe |
| pd_late | input | 1 | Detector sign: 1 late (raise offset), 0 early (lower offset) |
| dsm_out | output | 1 | Delta-sigma bit stream for the charge-pump offset current |
| offset_word | output | OFS_W | Current signed offset word (tracked base plus target) |
| locked | output | 1 | High in LOCKED |

## Verification
A start pulse and the last sample of a vote can fall in the same cycle. The restart then has to win: the decision is dropped, and the target and lock flag clear together. The bench provokes this by sending fifteen samples of a vote and then raising the sixteenth together with start while the controller is locked. Its scoreboard expects exactly one offset change, the removal of the target, and no ±1 step. A full vote afterwards must then produce exactly one step, which shows that the partial count was discarded.

// File: rtl/skew_trim_pkg.sv
package skew_trim_pkg;
    typedef enum logic [2:0] {
        ST_IDLE         = 3'd0,
        ST_ZERO_SEARCH  = 3'd1,
        ST_APPLY_TARGET = 3'd2,
        ST_TRACK        = 3'd3,
        ST_LOCKED       = 3'd4
    } cal_state_t;
endpackage

// File: rtl/pd_vote.sv
module pd_vote #(
    parameter int N = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic en,
    input  logic smp_valid,
    input  logic smp_late,
    output logic dec_valid,
    output logic dec_late
);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] seen_q;
    logic [CW-1:0] late_q;
    logic [CW-1:0] late_nx;

    always_comb begin
        late_nx = late_q + CW'(smp_late);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q    <= '0;
            late_q    <= '0;
            dec_valid <= 1'b0;
            dec_late  <= 1'b0;
        end else begin
            dec_valid <= 1'b0;
            if (clear) begin
                seen_q <= '0;
                late_q <= '0;
            end else if (en && smp_valid) begin
                if (seen_q == CW'(N - 1)) begin
                    dec_valid <= 1'b1;
                    dec_late  <= (late_nx > CW'(N / 2));
                    seen_q    <= '0;
                    late_q    <= '0;
                end else begin
                    seen_q <= seen_q + 1'b1;
                    late_q <= late_nx;
                end
            end
        end
    end

    // R3
    vote_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);
endmodule

// File: rtl/lock_detect.sv
module lock_detect #(
    parameter int LOCK_N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic dec_valid,
    input  logic dec_late,
    output logic alt_done
);
    localparam int AW = $clog2(LOCK_N + 1);

    logic [AW-1:0] alt_q;
    logic          have_q;
    logic          last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alt_q  <= '0;
            have_q <= 1'b0;
            last_q <= 1'b0;
        end else if (clear) begin
            alt_q  <= '0;
            have_q <= 1'b0;
            last_q <= 1'b0;
        end else if (dec_valid) begin
            if (have_q && (dec_late != last_q)) begin
                if (alt_q != AW'(LOCK_N)) begin
                    alt_q <= alt_q + 1'b1;
                end
            end else begin
                alt_q <= '0;
            end
            have_q <= 1'b1;
            last_q <= dec_late;
        end
    end

    always_comb begin
        alt_done = (alt_q == AW'(LOCK_N));
    end

    // R4
    alt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alt_done) |-> $past(dec_valid));
endmodule

// File: rtl/dsm_first_order.sv
module dsm_first_order #(
    parameter int W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] level,
    output logic                bit_o
);
    logic [W-1:0] acc_q;
    logic [W-1:0] bias;
    logic [W:0]   sum;

    always_comb begin
        bias = {~level[W-1], level[W-2:0]};
        sum  = {1'b0, acc_q} + {1'b0, bias};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            bit_o <= 1'b0;
        end else begin
            acc_q <= sum[W-1:0];
            bit_o <= sum[W];
        end
    end

    // R9
    half_density_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level[W-1] && $past(level[W-1]) && bit_o) |=> !bit_o);
endmodule

// File: rtl/skew_trim_ctrl.sv
module skew_trim_ctrl
    import skew_trim_pkg::*;
#(
    parameter int OFS_W   = 12,
    parameter int VOTE_N  = 16,
    parameter int LOCK_N  = 8,
    parameter int UI_CODE = 1024
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cal_start,
    input  logic signed [OFS_W-1:0] tgt_skew,
    input  logic                    pd_valid,
    input  logic                    pd_late,
    output logic                    dsm_out,
    output logic signed [OFS_W-1:0] offset_word,
    output logic                    locked
);
    localparam int XW = OFS_W + 1;
    localparam logic signed [XW-1:0] ONE     = XW'(1);
    localparam logic signed [XW-1:0] OFS_MAX = XW'((1 << (OFS_W - 1)) - 1);
    localparam logic signed [XW-1:0] OFS_MIN = -OFS_MAX;
    localparam logic signed [XW-1:0] TGT_MAX = XW'(UI_CODE - 1);
    localparam logic signed [XW-1:0] TGT_MIN = -TGT_MAX;

    function automatic logic signed [XW-1:0] sx(input logic signed [OFS_W-1:0] v);
        return {v[OFS_W-1], v};
    endfunction

    function automatic logic signed [OFS_W-1:0] clip(
        input logic signed [XW-1:0] v,
        input logic signed [XW-1:0] lo,
        input logic signed [XW-1:0] hi
    );
        logic signed [XW-1:0] t;
        t = (v > hi) ? hi : ((v < lo) ? lo : v);
        return t[OFS_W-1:0];
    endfunction

    cal_state_t st_q, st_d;

    logic signed [OFS_W-1:0] base_q;
    logic signed [OFS_W-1:0] tgt_q;
    logic signed [OFS_W-1:0] base_nx;
    logic signed [OFS_W-1:0] tgt_clip;
    logic                    dec_valid;
    logic                    dec_late;
    logic                    alt_done;
    logic                    vote_en;
    logic                    seq_clear;
    logic                    base_upd;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (cal_start) begin
            st_d = ST_ZERO_SEARCH;
        end else begin
            unique case (st_q)
                ST_IDLE:         st_d = ST_IDLE;
                ST_ZERO_SEARCH:  if (alt_done) st_d = ST_APPLY_TARGET;
                ST_APPLY_TARGET: st_d = ST_TRACK;
                ST_TRACK:        if (alt_done) st_d = ST_LOCKED;
                ST_LOCKED:       st_d = ST_LOCKED;
                default:         st_d = ST_IDLE;
            endcase
        end
    end

    // state outputs
    always_comb begin
        vote_en   = 1'b0;
        locked    = 1'b0;
        seq_clear = cal_start;
        unique case (st_q)
            ST_IDLE: begin
                vote_en = 1'b0;
            end
            ST_ZERO_SEARCH: begin
                vote_en = 1'b1;
            end
            ST_APPLY_TARGET: begin
                seq_clear = 1'b1;
            end
            ST_TRACK: begin
                vote_en = 1'b1;
            end
            ST_LOCKED: begin
                vote_en = 1'b1;
                locked  = 1'b1;
            end
            default: begin
                vote_en = 1'b0;
            end
        endcase
    end

    // offset datapath
    always_comb begin
        base_nx     = clip(sx(base_q) + (dec_late ? ONE : -ONE), OFS_MIN, OFS_MAX);
        tgt_clip    = clip(sx(tgt_skew), TGT_MIN, TGT_MAX);
        offset_word = clip(sx(base_q) + sx(tgt_q), OFS_MIN, OFS_MAX);
        base_upd    = dec_valid && (st_q != ST_IDLE) && !cal_start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            tgt_q  <= '0;
        end else begin
            if (base_upd) begin
                base_q <= base_nx;
            end
            if (cal_start) begin
                tgt_q <= '0;
            end else if (st_q == ST_APPLY_TARGET) begin
                tgt_q <= tgt_clip;
            end
        end
    end

    pd_vote #(.N(VOTE_N)) u_vote (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (seq_clear),
        .en        (vote_en),
        .smp_valid (pd_valid),
        .smp_late  (pd_late),
        .dec_valid (dec_valid),
        .dec_late  (dec_late)
    );

    lock_detect #(.LOCK_N(LOCK_N)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (seq_clear),
        .dec_valid (dec_valid),
        .dec_late  (dec_late),
        .alt_done  (alt_done)
    );

    dsm_first_order #(.W(OFS_W)) u_dsm (
        .clk   (clk),
        .rst_n (rst_n),
        .level (offset_word),
        .bit_o (dsm_out)
    );

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !cal_start) |=> $stable(offset_word));

    // R3
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ZERO_SEARCH && $past(st_q) == ST_ZERO_SEARCH) |->
            ((offset_word == $past(offset_word)) ||
             (offset_word == $past(offset_word) + OFS_W'(1)) ||
             (offset_word == $past(offset_word) - OFS_W'(1))));

    // R5
    tgt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sx(tgt_q) <= TGT_MAX) && (sx(tgt_q) >= TGT_MIN));

    // R6
    lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(st_q) == ST_TRACK));

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> (!locked && st_q == ST_ZERO_SEARCH && tgt_q == '0));
endmodule

// File: tb/skew_trim_ctrl_bench.sv
`timescale 1ns/1ps
module skew_trim_ctrl_bench;
    localparam int W    = 8;
    localparam int N    = 16;
    localparam int LN   = 8;
    localparam int UI   = 64;
    localparam int MAXV = (1 << (W - 1)) - 1;
    localparam int TMAX = UI - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cal_start = 1'b0;
    logic pd_valid = 1'b0;
    logic pd_late = 1'b0;
    logic signed [W-1:0] tgt_skew = '0;
    logic dsm_out;
    logic locked;
    logic signed [W-1:0] offset_word;

    always #4 clk = ~clk;

    skew_trim_ctrl #(.OFS_W(W), .VOTE_N(N), .LOCK_N(LN), .UI_CODE(UI)) u_skew_trim_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cal_start   (cal_start),
        .tgt_skew    (tgt_skew),
        .pd_valid    (pd_valid),
        .pd_late     (pd_late),
        .dsm_out     (dsm_out),
        .offset_word (offset_word),
        .locked      (locked)
    );

    typedef struct {
        int    val;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // bench model: 0 idle, 1 zero search, 3 track, 4 locked
    int m_base = 0;
    int m_tgt = 0;
    int m_off = 0;
    int m_state = 0;
    int m_cnt = 0;
    bit m_have = 1'b0;
    bit m_last = 1'b0;

    function automatic int sat(int v, int lim);
        if (v > lim) return lim;
        if (v < -lim) return -lim;
        return v;
    endfunction

    task automatic check(int act, int exp, string req, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_off(string req);
        int nv;
        nv = sat(m_base + m_tgt, MAXV);
        if (nv != m_off) begin
            exp_t e;
            e.val = nv;
            e.req = req;
            exp_q.push_back(e);
            m_off = nv;
        end
    endtask

    task automatic model_start();
        m_state = 1;
        m_tgt   = 0;
        m_cnt   = 0;
        m_have  = 1'b0;
        expect_off("R10");
    endtask

    task automatic model_decide(int n_late, string req);
        bit late;
        late = (n_late > N / 2);
        if (m_state == 0) return;
        m_base = sat(m_base + (late ? 1 : -1), MAXV);
        expect_off(req);
        if (m_have && (late != m_last)) begin
            if (m_cnt < LN) m_cnt++;
        end else begin
            m_cnt = 0;
        end
        m_have = 1'b1;
        m_last = late;
        if (m_cnt == LN) begin
            if (m_state == 1) begin
                m_tgt   = sat(int'(tgt_skew), TMAX);
                m_state = 3;
                m_cnt   = 0;
                m_have  = 1'b0;
                expect_off("R4");
            end else if (m_state == 3) begin
                m_state = 4;
            end
        end
    endtask

    // driver: one vote of N samples, n_late of them late
    task automatic send_block(int n_late, bit start_last, string req);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            pd_valid = 1'b1;
            pd_late  = (i < n_late);
            if (i == N - 1 && start_last) cal_start = 1'b1;
        end
        if (start_last) model_start();
        else model_decide(n_late, req);
        @(negedge clk);
        pd_valid  = 1'b0;
        pd_late   = 1'b0;
        cal_start = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_start();
        @(negedge clk);
        cal_start = 1'b1;
        model_start();
        @(negedge clk);
        cal_start = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic density(int exp, string req);
        int ones;
        ones = 0;
        @(negedge clk);
        repeat (1 << W) begin
            @(negedge clk);
            ones += int'(dsm_out);
        end
        check(ones, exp, req, "modulator ones per period");
    endtask

    task automatic drained(string req);
        repeat (2) @(negedge clk);
        check(exp_q.size(), 0, req, "pending scoreboard items");
        check(int'(offset_word), m_off, req, "offset word");
    endtask

    // alternating decisions starting with early, count of them = n
    task automatic alternate(int n, string req);
        for (int k = 0; k < n; k++) begin
            if (k % 2 == 0) send_block((k % 4 == 0) ? 8 : 3, 1'b0, req);
            else send_block((k % 4 == 1) ? 9 : 16, 1'b0, req);
        end
    endtask

    // monitor: every change of the offset word is popped and compared
    initial begin
        logic signed [W-1:0] prev;
        prev = '0;
        forever begin
            @(negedge clk);
            if (rst_n && (offset_word !== prev)) begin
                if (exp_q.size() == 0) begin
                    n_chk++;
                    n_fail++;
                    $display("FAIL R3 unexpected offset change: actual %0d expected %0d",
                             offset_word, prev);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(int'(offset_word), e.val, e.req, "offset step");
                end
            end
            prev = offset_word;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(int'(offset_word), 0, "R1", "offset after reset");
        check(int'(locked), 0, "R1", "locked after reset");
        check(int'(dsm_out), 0, "R1", "modulator bit after reset");
        // R9 mid-scale density
        density(1 << (W - 1), "R9");

        // R2 samples ignored in IDLE
        send_block(16, 1'b0, "R2");
        send_block(0, 1'b0, "R2");
        drained("R2");

        // R3/R4/R5 zero search with an out-of-range target
        tgt_skew = 8'sd100;
        do_start();
        send_block(12, 1'b0, "R3");
        send_block(16, 1'b0, "R3");
        send_block(9, 1'b0, "R3");
        send_block(0, 1'b0, "R3");
        drained("R3");
        check(int'(offset_word), 2, "R3", "after three late and one early vote");
        send_block(16, 1'b0, "R3");
        alternate(LN, "R4");
        drained("R5");
        check(int'(offset_word), 3 + TMAX, "R5", "clamped target added");
        check(int'(locked), 0, "R4", "no lock after zero search");

        // R6 tracking then lock
        send_block(10, 1'b0, "R6");
        send_block(14, 1'b0, "R6");
        alternate(LN - 1, "R6");
        check(int'(locked), 0, "R6", "lock before last alternation");
        send_block(16, 1'b0, "R6");
        check(int'(locked), 1, "R6", "lock after alternations");

        // R7 tracking continues when locked
        send_block(0, 1'b0, "R7");
        send_block(7, 1'b0, "R7");
        drained("R7");
        check(int'(locked), 1, "R7", "lock held while tracking");
        density(m_off + (1 << (W - 1)), "R9");

        // R10 start coincident with the final vote sample
        send_block(16, 1'b1, "R10");
        drained("R10");
        check(int'(locked), 0, "R10", "lock cleared by restart");
        check(int'(offset_word), m_base, "R10", "target removed on restart");
        send_block(16, 1'b0, "R10");
        drained("R10");

        // R5 negative clamp on a second search
        tgt_skew = -8'sd100;
        send_block(16, 1'b0, "R5");
        alternate(LN, "R5");
        drained("R5");
        check(int'(offset_word), m_base - TMAX, "R5", "negative clamped target");
        check(int'(locked), 0, "R6", "track without lock");

        // R8 saturation both ways
        do_start();
        repeat (140) send_block(16, 1'b0, "R8");
        drained("R8");
        check(int'(offset_word), MAXV, "R8", "positive saturation");
        density(MAXV + (1 << (W - 1)), "R9");
        repeat (260) send_block(0, 1'b0, "R8");
        drained("R8");
        check(int'(offset_word), -MAXV, "R8", "negative saturation");
        density(1, "R9");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule